// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block selects the slow timebase used by a real-time-clock domain. It can take either an internal RC oscillator or an external crystal oscillator. When the internal source is selected, the block divides it by a programmable factor. When the external source is selected, every external edge passes through with no division. A separately gated copy of the selected timebase is provided for an output pin.

All logic runs on one system clock. Each oscillator is presented to the block as a one-cycle tick, one tick per oscillator period. The selected timebase and its pin copy leave the block as one-cycle ticks in the same domain. Software reaches the block through a simple synchronous register port with address, write data, write strobe and combinational read data. A write to the source-select register is honoured only when a 16-bit unlock key sits in the upper half of the write data.

Top module: `lsclk_select`

## Requirements
- R1: After reset, reads at offsets 0x00, 0x08 and 0x60 all return 0: the internal source is selected, the prescaler is 0 and the pin gate is off. `ls_tick` and `pin_tick` are low.
- R2: A write to offset 0x00 whose data bits [31:16] equal 0x16AA stores data bit 0 as the source select: 0 selects the internal oscillator and 1 selects the external one.
- R3: A write to offset 0x00 with any other value in bits [31:16] leaves the source select unchanged.
- R4: A read at offset 0x00 returns the source select in bit 0 and 0 in bits [31:1]. The key is not stored.
- R5: Offset 0x08 holds a 5-bit prescaler in data bits [4:0]. A read returns it in bits [4:0] with 0 above. A write to it restarts the divider count.
- R6: With the internal source selected and prescaler value N, `ls_tick` pulses on every (N+1)-th internal tick counted from the last prescaler write. The first pulse comes on tick N+1.
- R7: With the external source selected, every external tick produces an `ls_tick` pulse. Internal ticks and the prescaler value have no effect on the output.
- R8: Bit 0 of offset 0x60 gates the pin copy. When it is 1, `pin_tick` equals `ls_tick`. When it is 0, `pin_tick` stays low.
- R9: `ls_tick` and `pin_tick` rise in the clock cycle after the source tick that causes them.
- R10: Reads at any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| int_osc_tick | input | 1 | One pulse per internal oscillator period |
| ext_osc_tick | input | 1 | One pulse per external oscillator period |
| ls_tick | output | 1 | Selected low-speed timebase tick |
| pin_tick | output | 1 | Gated copy of `ls_tick` for the pin |

## Verification
Read data is combinational, so the bench samples it within the same cycle, shortly after it sets the address. A register write takes effect at the first rising edge that sees the strobe, and the bench reads back only after that edge. Each source tick reaches `ls_tick` and `pin_tick` through one output register. The bench raises a tick on a falling edge and checks that the outputs are still low before the next rising edge. It then checks that they are high at the following falling edge, which is exactly one cycle later. For divider tests, the bench restarts the count with a prescaler write and predicts the output of every tick from its position in the sequence.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;

   typedef enum logic {
      SRC_INTERNAL = 1'b0,
      SRC_EXTERNAL = 1'b1
   } lsclk_src_e;

   localparam logic [15:0] LSCLK_UNLOCK = 16'h16AA;

   localparam logic [7:0] OFS_SRC_SEL = 8'h00;
   localparam logic [7:0] OFS_PRESCALE = 8'h08;
   localparam logic [7:0] OFS_PIN_GATE = 8'h60;

endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
   import lsclk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int PRE_W = 5,
   parameter int KEY_W = 16,
   parameter logic [KEY_W-1:0] KEY_VALUE = LSCLK_UNLOCK,
   parameter bit KEY_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   output logic [DATA_W-1:0] rdata,
   output lsclk_src_e        src_sel,
   output logic [PRE_W-1:0]  prescale,
   output logic              gate_en,
   output logic              presc_wr
);

   localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(OFS_SRC_SEL);
   localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(OFS_PRESCALE);
   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(OFS_PIN_GATE);
   localparam int KEY_LSB = DATA_W - KEY_W;

   if (DATA_W < KEY_W + PRE_W + 1) begin : g_bad_width
      $error("lsclk_regs: DATA_W too small for key and prescaler fields");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("lsclk_regs: ADDR_W cannot reach the pin gate offset");
   end

   logic key_ok;
   logic hit_src, hit_pre, hit_gate;

   if (KEY_CHECK) begin : g_keyed
      assign key_ok = (wdata[DATA_W-1:KEY_LSB] == KEY_VALUE);
   end else begin : g_open
      assign key_ok = 1'b1;
   end

   assign hit_src = (addr == A_SRC);
   assign hit_pre = (addr == A_PRE);
   assign hit_gate = (addr == A_GATE);
   assign presc_wr = we && hit_pre;

   logic unused_wbits;
   assign unused_wbits = ^wdata[KEY_LSB-1:PRE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_sel <= SRC_INTERNAL;
         prescale <= '0;
         gate_en <= 1'b0;
      end else if (we) begin
         if (hit_src && key_ok) begin
            src_sel <= lsclk_src_e'(wdata[0]);
         end
         if (hit_pre) begin
            prescale <= wdata[PRE_W-1:0];
         end
         if (hit_gate) begin
            gate_en <= wdata[0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_src) begin
         rdata[0] = src_sel;
      end else if (hit_pre) begin
         rdata[PRE_W-1:0] = prescale;
      end else if (hit_gate) begin
         rdata[0] = gate_en;
      end
   end

endmodule

// File: rtl/lsclk_prescale.sv
module lsclk_prescale #(
   parameter int PRE_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             src_tick,
   input  logic [PRE_W-1:0] div,
   output logic             div_tick
);

   if (PRE_W < 1) begin : g_bad_pre
      $error("lsclk_prescale: PRE_W must be at least 1");
   end

   logic [PRE_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt >= div);
   assign div_tick = src_tick && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (src_tick) begin
         if (wrap) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lsclk_outsel.sv
module lsclk_outsel
   import lsclk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  lsclk_src_e src_sel,
   input  logic       int_div_tick,
   input  logic       ext_tick,
   input  logic       gate_en,
   output logic       ls_tick,
   output logic       pin_tick
);

   logic chosen;

   always_comb begin
      unique case (src_sel)
         SRC_EXTERNAL: chosen = ext_tick;
         default:      chosen = int_div_tick;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ls_tick <= 1'b0;
         pin_tick <= 1'b0;
      end else begin
         ls_tick <= chosen;
         pin_tick <= chosen && gate_en;
      end
   end

endmodule

// File: rtl/lsclk_select.sv
module lsclk_select
   import lsclk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int PRE_W = 5,
   parameter int KEY_W = 16,
   parameter bit KEY_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_we,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              int_osc_tick,
   input  logic              ext_osc_tick,
   output logic              ls_tick,
   output logic              pin_tick
);

   lsclk_src_e       src_sel_w;
   logic [PRE_W-1:0] prescale_w;
   logic             gate_w;
   logic             presc_wr_w;
   logic             int_div_w;

   lsclk_regs #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .PRE_W(PRE_W),
      .KEY_W(KEY_W),
      .KEY_VALUE(KEY_W'(LSCLK_UNLOCK)),
      .KEY_CHECK(KEY_CHECK)
   ) u_regs (
      .clk(clk),
      .rst_n(rst_n),
      .addr(reg_addr),
      .wdata(reg_wdata),
      .we(reg_we),
      .rdata(reg_rdata),
      .src_sel(src_sel_w),
      .prescale(prescale_w),
      .gate_en(gate_w),
      .presc_wr(presc_wr_w)
   );

   lsclk_prescale #(
      .PRE_W(PRE_W)
   ) u_div (
      .clk(clk),
      .rst_n(rst_n),
      .clr(presc_wr_w),
      .src_tick(int_osc_tick),
      .div(prescale_w),
      .div_tick(int_div_w)
   );

   lsclk_outsel u_out (
      .clk(clk),
      .rst_n(rst_n),
      .src_sel(src_sel_w),
      .int_div_tick(int_div_w),
      .ext_tick(ext_osc_tick),
      .gate_en(gate_w),
      .ls_tick(ls_tick),
      .pin_tick(pin_tick)
   );

endmodule

// File: rtl/lsclk_select_chk.sv
module lsclk_select_chk
   import lsclk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int PRE_W = 5,
   parameter int KEY_W = 16,
   parameter bit KEY_CHECK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [KEY_W-1:0]  wkey,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              int_osc_tick,
   input logic              ext_osc_tick,
   input logic              ls_tick,
   input logic              pin_tick,
   input lsclk_src_e        src_sel,
   input logic [PRE_W-1:0]  prescale
);

   localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(OFS_SRC_SEL);
   localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(OFS_PRESCALE);
   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(OFS_PIN_GATE);

   if (KEY_CHECK) begin : g_key_prop
      p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && reg_addr == A_SRC && wkey != KEY_W'(LSCLK_UNLOCK)) |=> $stable(src_sel));
   end

   p_ctrl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_SRC) |-> (reg_rdata[DATA_W-1:1] == '0));

   p_pre_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_PRE) |-> (reg_rdata[DATA_W-1:PRE_W] == '0));

   p_div_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_INTERNAL && prescale == '0 && int_osc_tick) |=> ls_tick);

   p_ext_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_EXTERNAL && ext_osc_tick) |=> ls_tick);

   p_ext_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_EXTERNAL && !ext_osc_tick) |=> !ls_tick);

   p_pin_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_tick |-> ls_tick);

   p_hole_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != A_SRC && reg_addr != A_PRE && reg_addr != A_GATE) |-> (reg_rdata == '0));

endmodule

bind lsclk_select lsclk_select_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .PRE_W(PRE_W),
   .KEY_W(KEY_W),
   .KEY_CHECK(KEY_CHECK)
) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .reg_addr(reg_addr),
   .wkey(reg_wdata[DATA_W-1:DATA_W-KEY_W]),
   .reg_we(reg_we),
   .reg_rdata(reg_rdata),
   .int_osc_tick(int_osc_tick),
   .ext_osc_tick(ext_osc_tick),
   .ls_tick(ls_tick),
   .pin_tick(pin_tick),
   .src_sel(src_sel_w),
   .prescale(prescale_w)
);

// File: tb/tb_lsclk_select.sv
`timescale 1ns/1ps
module tb_lsclk_select;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic        int_osc_tick = 1'b0;
   logic        ext_osc_tick = 1'b0;
   logic        ls_tick;
   logic        pin_tick;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lsclk_select dut (
      .clk(clk),
      .rst_n(rst_n),
      .reg_addr(reg_addr),
      .reg_wdata(reg_wdata),
      .reg_we(reg_we),
      .reg_rdata(reg_rdata),
      .int_osc_tick(int_osc_tick),
      .ext_osc_tick(ext_osc_tick),
      .ls_tick(ls_tick),
      .pin_tick(pin_tick)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      reg_wdata = d;
      reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   // Raise one source tick and return the outputs one cycle later
   task automatic pulse(input bit ext, output logic ls, output logic pin);
      @(negedge clk);
      if (ext) ext_osc_tick = 1'b1;
      else int_osc_tick = 1'b1;
      #0.5;
      check("R9 output low before edge", {30'b0, ls_tick, pin_tick}, 32'h0);
      @(negedge clk);
      int_osc_tick = 1'b0;
      ext_osc_tick = 1'b0;
      ls = ls_tick;
      pin = pin_tick;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h00, d); check("R1 source select after reset", d, 32'h0);
      rd(8'h08, d); check("R1 prescaler after reset", d, 32'h0);
      rd(8'h60, d); check("R1 pin gate after reset", d, 32'h0);
      check("R1 outputs after reset", {30'b0, ls_tick, pin_tick}, 32'h0);
   endtask

   task automatic t_int_undivided();
      logic ls, pin;
      pulse(1'b0, ls, pin);
      check("R6 R9 internal tick passes with prescaler 0", {31'b0, ls}, 32'h1);
      check("R8 pin stays low while gate off", {31'b0, pin}, 32'h0);
   endtask

   task automatic t_gate();
      logic [31:0] d;
      logic ls, pin;
      wr(8'h60, 32'hFFFF_FFFF);
      rd(8'h60, d); check("R8 gate readback", d, 32'h1);
      pulse(1'b0, ls, pin);
      check("R8 pin follows timebase when gated on", {30'b0, ls, pin}, 32'h3);
   endtask

   task automatic t_divide(input logic [4:0] n, input int ticks);
      logic [31:0] d;
      logic ls, pin;
      wr(8'h08, {27'h7FF_FFFF, n});
      rd(8'h08, d); check("R5 prescaler readback", d, {27'b0, n});
      for (int k = 1; k <= ticks; k++) begin
         pulse(1'b0, ls, pin);
         check("R6 divided internal tick", {31'b0, ls}, {31'b0, (k % (n + 1)) == 0});
      end
   endtask

   task automatic t_keys();
      logic [31:0] d;
      logic ls, pin;
      wr(8'h08, 32'h0);
      wr(8'h00, 32'h1234_0001);
      rd(8'h00, d); check("R3 wrong key ignored", d, 32'h0);
      pulse(1'b1, ls, pin);
      check("R3 external tick blocked after bad key", {31'b0, ls}, 32'h0);
      wr(8'h00, 32'h16AA_FFFF);
      rd(8'h00, d); check("R2 R4 keyed write selects external", d, 32'h1);
   endtask

   task automatic t_external();
      logic [31:0] d;
      logic ls, pin;
      wr(8'h08, 32'h0000_0007);
      for (int k = 0; k < 3; k++) begin
         pulse(1'b1, ls, pin);
         check("R7 every external tick passes", {30'b0, ls, pin}, 32'h3);
      end
      pulse(1'b0, ls, pin);
      check("R7 internal tick ignored while external", {30'b0, ls, pin}, 32'h0);
      wr(8'h00, 32'h16AA_0000);
      rd(8'h00, d); check("R2 keyed write selects internal", d, 32'h0);
   endtask

   task automatic t_holes();
      logic [31:0] d;
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, d); check("R10 unmapped read", d, 32'h0);
      rd(8'h08, d); check("R10 prescaler untouched", d, 32'h7);
      rd(8'h60, d); check("R10 gate untouched", d, 32'h1);
      rd(8'h00, d); check("R10 source untouched", d, 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_int_undivided();
      t_gate();
      t_divide(5'd3, 8);
      t_divide(5'd1, 4);
      t_divide(5'd31, 32);
      t_keys();
      t_external();
      t_holes();
      finish_run();
   end

endmodule